// File: doc/BRIEF.md
# Loop Schedule Shape Configuration Unit

This unit carries out the shape-setup step for a vector loop sequencer. A single start pulse hands it three 5-bit dimension values, a 4-bit schedule mode and a vertical-first flag. From these it works out a 7-bit loop length. It then fills four 32-bit shape descriptors, which downstream remapping logic uses to walk operands through a matrix multiply, an FFT butterfly or a DCT inner butterfly. It also rewrites a 64-bit vector-state word that carries the new length.

Each operation first clears the state word and every descriptor. The unit builds a template for the chosen mode, copies it into the descriptors that mode uses, and then changes a few fields in each copy. For the two butterfly modes, the length is the transform size multiplied by the number of consecutive one bits at the low end of the x dimension.

The work takes several cycles: one to capture the request, two for the multiplies and one to write the results. A one-cycle done pulse marks the cycle in which the new values first appear.

Top module: `loop_shape_cfg`

## Requirements
- R1: While reset is high and after it is released, `done` is low and all four shapes and the state word read zero.
- R2: A start seen in idle is captured at that rising edge. `done` pulses high for exactly one cycle after the third following edge, and all outputs change at that edge only. They hold until the next done pulse.
- R3: A start that arrives while an operation is in progress is ignored. It causes no extra done pulse and does not change the result.
- R4: A start presented in the same cycle as `done` is accepted, so operations can run back to back.
- R5: The state word is all zero apart from three fields: the length in bits [6:0], the same length in bits [13:7], and the vertical-first flag in bit 63.
- R6: In mode 0 (matrix), the length is the low 7 bits of x*y*z.
- R7: In mode 0, the shape fields are placed as follows: x at [5:0], y at [11:6] and z at [17:12], all zero-extended. Shapes 0 and 3 hold permute [20:18]=0 and skip [29:28]=3. Shape 1 holds permute 1 and skip 1. Shape 2 holds permute 1 and skip 3. The kind field [31:30] is 0 in all four.
- R8: In modes 1 and 2 (butterfly), let t be the count of consecutive ones in x, counted upward from bit 0. The length is the low 7 bits of (x+1)*t.
- R9: In mode 1 (FFT), shape 0 holds x at [5:0] and kind [31:30]=1. Shape 1 equals shape 0 with skip 1. Shape 2 equals shape 0 with skip 2. Shape 3 is zero.
- R10: In mode 2 (DCT), shape 0 holds x at [5:0], permute [20:18]=1 and kind 1. Shape 1 equals shape 0 with skip 1. Shapes 2 and 3 are zero.
- R11: For any mode value from 3 to 15, all shapes are zero and the length is zero. The vertical-first bit is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; inputs sampled with it |
| x_dim | input | 5 | X dimension / transform size field |
| y_dim | input | 5 | Y dimension |
| z_dim | input | 5 | Z dimension |
| mode | input | 4 | Schedule mode |
| vfirst | input | 1 | Vertical-first flag |
| done | output | 1 | One-cycle completion pulse |
| shape0 | output | 32 | Shape descriptor 0 |
| shape1 | output | 32 | Shape descriptor 1 |
| shape2 | output | 32 | Shape descriptor 2 |
| shape3 | output | 32 | Shape descriptor 3 |
| state_o | output | 64 | Vector-state word |

## Verification
Two events can land in the same cycle: a new start request and the completion of the previous operation. The bench provokes this by raising start in exactly the cycle in which done is observed high. It then requires that the second request completes four edges later, with its own results intact. It also holds start high during the busy cycles and checks that neither the latency nor the result of the running operation changes.

// File: rtl/loop_shape_pkg.sv
package loop_shape_pkg;

    localparam int DIM_W      = 5;
    localparam int FLD_W      = DIM_W + 1;
    localparam int LEN_W      = 7;
    localparam int SHAPE_W    = 32;
    localparam int STATE_W    = 64;
    localparam int NUM_SHAPES = 4;
    localparam int MODE_W     = 4;
    localparam int CNT_W      = $clog2(DIM_W + 1);

    // descriptor field positions (decoded by the remapper)
    localparam int X_LSB    = 0;
    localparam int Y_LSB    = 6;
    localparam int Z_LSB    = 12;
    localparam int PERM_LSB = 18;
    localparam int PERM_W   = 3;
    localparam int SKIP_LSB = 28;
    localparam int SKIP_W   = 2;
    localparam int KIND_LSB = 30;
    localparam int KIND_W   = 2;

    // state word positions
    localparam int ST_MAX_LSB = 0;
    localparam int ST_CUR_LSB = 7;
    localparam int ST_VF_BIT  = 63;

    typedef logic [MODE_W-1:0]  mode_t;
    typedef logic [SHAPE_W-1:0] shape_t;

    localparam mode_t MODE_MATRIX = 4'd0;
    localparam mode_t MODE_FFT    = 4'd1;
    localparam mode_t MODE_DCT    = 4'd2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MUL1,
        PH_MUL2,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        logic [DIM_W-1:0] xd;
        logic [DIM_W-1:0] yd;
        logic [DIM_W-1:0] zd;
        mode_t            mode;
        logic             vf;
    } req_t;

    // run of ones from bit 0 upward
    function automatic logic [CNT_W-1:0] low_ones(input logic [DIM_W-1:0] v);
        int  n;
        bit  stop;
        n    = 0;
        stop = 1'b0;
        for (int i = 0; i < DIM_W; i++) begin
            if (!stop) begin
                if (v[i]) n++;
                else      stop = 1'b1;
            end
        end
        return CNT_W'(n);
    endfunction

    function automatic shape_t put_field(input shape_t s, input int lsb,
                                         input int w, input logic [7:0] val);
        shape_t r;
        r = s;
        for (int i = 0; i < 8; i++) begin
            if (i < w) r[lsb + i] = val[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/loop_shape_ctrl.sv
module loop_shape_ctrl
    import loop_shape_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   accept
);

    phase_e phase_q;

    assign accept = (phase_q == PH_IDLE) && start;
    assign phase  = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:  if (start) phase_q <= PH_MUL1;
                PH_MUL1:  phase_q <= PH_MUL2;
                PH_MUL2:  phase_q <= PH_WRITE;
                PH_WRITE: phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/loop_shape_len.sv
module loop_shape_len
    import loop_shape_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step1,
    input  logic             step2,
    input  logic [DIM_W-1:0] xd,
    input  logic [DIM_W-1:0] yd,
    input  logic [DIM_W-1:0] zd,
    input  mode_t            mode,
    output logic [LEN_W-1:0] len
);

    logic             is_mat;
    logic             is_bfly;
    logic [FLD_W-1:0] opa;
    logic [FLD_W-1:0] opb;
    logic [LEN_W-1:0] prod1;
    logic [LEN_W-1:0] prod2;
    logic [LEN_W-1:0] part_q;
    logic [LEN_W-1:0] len_q;

    always_comb begin
        is_mat  = (mode == MODE_MATRIX);
        is_bfly = (mode == MODE_FFT) || (mode == MODE_DCT);
        opa     = is_mat ? FLD_W'(xd) : FLD_W'(xd) + FLD_W'(1);
        opb     = is_mat ? FLD_W'(yd) : FLD_W'(low_ones(xd));
        // only the low bits survive, so truncated operands suffice
        prod1   = LEN_W'(opa) * LEN_W'(opb);
        prod2   = part_q * LEN_W'(zd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            len_q  <= '0;
        end else begin
            if (step1) part_q <= prod1;
            if (step2) len_q  <= is_mat ? prod2 : (is_bfly ? part_q : '0);
        end
    end

    assign len = len_q;

endmodule

// File: rtl/loop_shape_fill.sv
module loop_shape_fill
    import loop_shape_pkg::*;
(
    input  logic [DIM_W-1:0]                  xd,
    input  logic [DIM_W-1:0]                  yd,
    input  logic [DIM_W-1:0]                  zd,
    input  mode_t                             mode,
    output logic [NUM_SHAPES-1:0][SHAPE_W-1:0] shapes
);

    shape_t tmpl;

    always_comb begin
        tmpl   = '0;
        shapes = '0;
        unique case (mode)
            MODE_MATRIX: begin
                tmpl = put_field(tmpl, X_LSB, FLD_W, 8'(xd));
                tmpl = put_field(tmpl, Y_LSB, FLD_W, 8'(yd));
                tmpl = put_field(tmpl, Z_LSB, FLD_W, 8'(zd));
                tmpl = put_field(tmpl, SKIP_LSB, SKIP_W, 8'd3);
                for (int i = 0; i < NUM_SHAPES; i++) shapes[i] = tmpl;
                shapes[1] = put_field(put_field(tmpl, PERM_LSB, PERM_W, 8'd1),
                                      SKIP_LSB, SKIP_W, 8'd1);
                shapes[2] = put_field(tmpl, PERM_LSB, PERM_W, 8'd1);
            end
            MODE_FFT: begin
                tmpl = put_field(tmpl, X_LSB, FLD_W, 8'(xd));
                tmpl = put_field(tmpl, KIND_LSB, KIND_W, 8'd1);
                shapes[0] = tmpl;
                shapes[1] = put_field(tmpl, SKIP_LSB, SKIP_W, 8'd1);
                shapes[2] = put_field(tmpl, SKIP_LSB, SKIP_W, 8'd2);
            end
            MODE_DCT: begin
                tmpl = put_field(tmpl, X_LSB, FLD_W, 8'(xd));
                tmpl = put_field(tmpl, KIND_LSB, KIND_W, 8'd1);
                tmpl = put_field(tmpl, PERM_LSB, PERM_W, 8'd1);
                shapes[0] = tmpl;
                shapes[1] = put_field(tmpl, SKIP_LSB, SKIP_W, 8'd1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/loop_shape_cfg.sv
module loop_shape_cfg
    import loop_shape_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [DIM_W-1:0]         x_dim,
    input  logic [DIM_W-1:0]         y_dim,
    input  logic [DIM_W-1:0]         z_dim,
    input  logic [MODE_W-1:0]        mode,
    input  logic                     vfirst,
    output logic                     done,
    output logic [SHAPE_W-1:0]       shape0,
    output logic [SHAPE_W-1:0]       shape1,
    output logic [SHAPE_W-1:0]       shape2,
    output logic [SHAPE_W-1:0]       shape3,
    output logic [STATE_W-1:0]       state_o
);

    phase_e                            phase;
    logic                              accept;
    req_t                              req_q;
    logic [LEN_W-1:0]                  len;
    logic [NUM_SHAPES-1:0][SHAPE_W-1:0] shapes_nx;
    logic [NUM_SHAPES-1:0][SHAPE_W-1:0] shapes_q;
    logic [STATE_W-1:0]                state_nx;
    logic [STATE_W-1:0]                state_q;
    logic                              done_q;
    logic                              wr_en;

    loop_shape_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .phase  (phase),
        .accept (accept)
    );

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= '{xd: x_dim, yd: y_dim, zd: z_dim,
                                    mode: mode, vf: vfirst};
    end

    loop_shape_len u_len (
        .clk   (clk),
        .rst   (rst),
        .step1 (phase == PH_MUL1),
        .step2 (phase == PH_MUL2),
        .xd    (req_q.xd),
        .yd    (req_q.yd),
        .zd    (req_q.zd),
        .mode  (req_q.mode),
        .len   (len)
    );

    loop_shape_fill u_fill (
        .xd     (req_q.xd),
        .yd     (req_q.yd),
        .zd     (req_q.zd),
        .mode   (req_q.mode),
        .shapes (shapes_nx)
    );

    assign wr_en = (phase == PH_WRITE);

    always_comb begin
        state_nx                           = '0;
        state_nx[ST_MAX_LSB +: LEN_W]      = len;
        state_nx[ST_CUR_LSB +: LEN_W]      = len;
        state_nx[ST_VF_BIT]                = req_q.vf;
    end

    for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_shape_reg
        always_ff @(posedge clk) begin
            if (rst)        shapes_q[g] <= '0;
            else if (wr_en) shapes_q[g] <= shapes_nx[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= wr_en;
            if (wr_en) state_q <= state_nx;
        end
    end

    assign done    = done_q;
    assign shape0  = shapes_q[0];
    assign shape1  = shapes_q[1];
    assign shape2  = shapes_q[2];
    assign shape3  = shapes_q[3];
    assign state_o = state_q;

endmodule

// File: rtl/loop_shape_cfg_chk.sv
module loop_shape_cfg_chk
    import loop_shape_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic [SHAPE_W-1:0] shape0,
    input logic [SHAPE_W-1:0] shape1,
    input logic [SHAPE_W-1:0] shape2,
    input logic [SHAPE_W-1:0] shape3,
    input logic [STATE_W-1:0] state_o
);

    logic       busy;
    logic [1:0] age;
    logic       due;

    assign due = busy && (age == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            age  <= '0;
        end else if (busy) begin
            if (due) begin
                busy <= 1'b0;
                age  <= '0;
            end else begin
                age <= age + 2'd1;
            end
        end else if (start) begin
            busy <= 1'b1;
            age  <= 2'd1;
        end
    end

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        due |=> done);

    p_no_extra_done_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(due));

    p_hold_outputs_r2: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(shape0) && $stable(shape1) && $stable(shape2)
                   && $stable(shape3) && $stable(state_o)));

    p_state_layout_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_o[ST_CUR_LSB +: LEN_W] == state_o[ST_MAX_LSB +: LEN_W]
                  && state_o[ST_VF_BIT-1:ST_CUR_LSB+LEN_W] == '0));

    p_copy_matrix_r7: assert property (@(posedge clk) disable iff (rst)
        (done && shape3 != '0) |-> (shape3 == shape0));

    p_copy_low_r9: assert property (@(posedge clk) disable iff (rst)
        (done && shape1 != '0) |-> (shape1[Z_LSB+FLD_W-1:0] == shape0[Z_LSB+FLD_W-1:0]));

    p_empty_r11: assert property (@(posedge clk) disable iff (rst)
        (done && shape0 == '0) |-> (shape1 == '0 && shape2 == '0 && shape3 == '0));

endmodule

bind loop_shape_cfg loop_shape_cfg_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .shape0  (shape0),
    .shape1  (shape1),
    .shape2  (shape2),
    .shape3  (shape3),
    .state_o (state_o)
);

// File: tb/loop_shape_cfg_bench.sv
`timescale 1ns/1ps
module loop_shape_cfg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  x_dim = '0, y_dim = '0, z_dim = '0;
    logic [3:0]  mode = '0;
    logic        vfirst = 1'b0;
    logic        done;
    logic [31:0] shape0, shape1, shape2, shape3;
    logic [63:0] state_o;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    loop_shape_cfg u_loop_shape_cfg (
        .clk(clk), .rst(rst), .start(start),
        .x_dim(x_dim), .y_dim(y_dim), .z_dim(z_dim),
        .mode(mode), .vfirst(vfirst), .done(done),
        .shape0(shape0), .shape1(shape1), .shape2(shape2), .shape3(shape3),
        .state_o(state_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int ones_run(input int x);
        int n = 0;
        while (n < 5 && ((x >> n) & 1) == 1) n++;
        return n;
    endfunction

    function automatic logic [6:0] e_len(input int x, y, z, input int m);
        if (m == 0) return 7'((x * y * z) % 128);
        if (m == 1 || m == 2) return 7'(((x + 1) * ones_run(x)) % 128);
        return 7'd0;
    endfunction

    function automatic logic [31:0] pack_fields(input int x, y, z, perm, skip, kind);
        logic [31:0] v;
        v = 32'(x) | (32'(y) << 6) | (32'(z) << 12) | (32'(perm) << 18)
          | (32'(skip) << 28) | (32'(kind) << 30);
        return v;
    endfunction

    function automatic logic [31:0] e_shape(input int idx, input int x, y, z, input int m);
        if (m == 0) begin
            if (idx == 1) return pack_fields(x, y, z, 1, 1, 0);
            if (idx == 2) return pack_fields(x, y, z, 1, 3, 0);
            return pack_fields(x, y, z, 0, 3, 0);
        end
        if (m == 1) begin
            if (idx == 0) return pack_fields(x, 0, 0, 0, 0, 1);
            if (idx == 1) return pack_fields(x, 0, 0, 0, 1, 1);
            if (idx == 2) return pack_fields(x, 0, 0, 0, 2, 1);
            return 32'd0;
        end
        if (m == 2) begin
            if (idx == 0) return pack_fields(x, 0, 0, 1, 0, 1);
            if (idx == 1) return pack_fields(x, 0, 0, 1, 1, 1);
            return 32'd0;
        end
        return 32'd0;
    endfunction

    // called at a negedge: present one request for one rising edge
    task automatic issue(input int x, y, z, m, input bit vf);
        x_dim = 5'(x); y_dim = 5'(y); z_dim = 5'(z); mode = 4'(m); vfirst = vf;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        x_dim = ~5'(x); y_dim = ~5'(y); z_dim = ~5'(z); mode = ~4'(m); vfirst = ~vf;
    endtask

    // entered at the negedge after the accepting edge; returns at the done negedge
    task automatic await_check(input int x, y, z, m, input bit vf);
        int lat = 1;
        string tl, ts;
        logic [6:0] el;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R2 latency", 64'(lat), 64'd4);
        tl = (m == 0) ? "R6 length" : ((m == 1 || m == 2) ? "R8 length" : "R11 length");
        ts = (m == 0) ? "R7 shape" : (m == 1) ? "R9 shape" : (m == 2) ? "R10 shape" : "R11 shape";
        el = e_len(x, y, z, m);
        chk(tl, 64'(state_o[6:0]), 64'(el));
        chk("R5 state", state_o, {vf, 49'd0, el, el});
        chk({ts, "0"}, 64'(shape0), 64'(e_shape(0, x, y, z, m)));
        chk({ts, "1"}, 64'(shape1), 64'(e_shape(1, x, y, z, m)));
        chk({ts, "2"}, 64'(shape2), 64'(e_shape(2, x, y, z, m)));
        chk({ts, "3"}, 64'(shape3), 64'(e_shape(3, x, y, z, m)));
    endtask

    task automatic run_op(input int x, y, z, m, input bit vf);
        logic [63:0] st;
        logic [31:0] s0;
        issue(x, y, z, m, vf);
        await_check(x, y, z, m, vf);
        st = state_o; s0 = shape0;
        @(negedge clk);
        chk("R2 done single", 64'(done), 64'd0);
        chk("R2 hold state", state_o, st);
        chk("R2 hold shape", 64'(shape0), 64'(s0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 state in reset", state_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 state", state_o, 64'd0);
        chk("R1 shapes", 64'(shape0 | shape1 | shape2 | shape3), 64'd0);

        // R6 R7: matrix sweep
        for (int x = 0; x < 32; x++)
            for (int y = 0; y < 32; y += 3)
                for (int zi = 0; zi < 3; zi++)
                    run_op(x, y, (zi == 0) ? 1 : (zi == 1) ? 7 : 31, 0, (x % 2) == 1);

        // R8 R9 R10: butterfly modes, full size sweep, both flags
        for (int m = 1; m <= 2; m++)
            for (int x = 0; x < 32; x++)
                for (int v = 0; v < 2; v++)
                    run_op(x, 31 - x, x ^ 5, m, v == 1);

        // R11: unused mode values
        for (int m = 3; m < 16; m++)
            for (int x = 0; x < 32; x += 7)
                run_op(x, 9, 13, m, (m % 2) == 0);

        // R3: start held while busy must be ignored
        issue(6, 3, 2, 0, 1'b1);
        x_dim = 5'd31; y_dim = 5'd31; z_dim = 5'd31; mode = 4'd1; vfirst = 1'b0;
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        begin
            int lat = 3;
            while (!done && lat < 20) begin @(negedge clk); lat++; end
            chk("R3 latency unchanged", 64'(lat), 64'd4);
            chk("R3 result kept", state_o, {1'b1, 49'd0, 7'd36, 7'd36});
            chk("R3 shape kept", 64'(shape0), 64'(e_shape(0, 6, 3, 2, 0)));
        end
        begin
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R3 no extra done", 64'(extra), 64'd0);
        end

        // R4: start in the done cycle
        issue(7, 0, 0, 1, 1'b0);
        await_check(7, 0, 0, 1, 1'b0);
        chk("R4 done present", 64'(done), 64'd1);
        issue(5, 4, 3, 0, 1'b1);
        await_check(5, 4, 3, 0, 1'b1);
        issue(3, 0, 0, 2, 1'b0);
        await_check(3, 0, 0, 2, 1'b0);
        @(negedge clk);
        chk("R4 back-to-back ends", 64'(done), 64'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule